// File: doc/BRIEF.md
# Programmable 3x3 Color Space Converter

This block converts a stream of three-component pixels, for example luma and two chroma samples, into three output components such as red, green and blue. Every output row is a weighted sum of the three inputs. Before the multiply, a signed offset is added to each input component. After the sum, a signed constant is added, and the result is rounded and clamped to the 10-bit component range. A pixel is a set of three 10-bit components qualified by a valid strobe. Results appear a fixed three cycles later with their own valid strobe.

Software writes twelve 32-bit words into a staging bank through a simple write port. The bank that the datapath uses is refreshed from the staging bank only on a frame-start pulse. The same pulse also samples a conversion-enable level and a chroma-swap level. The chroma swap lets the block accept data with the two chroma planes in reversed order. When conversion is disabled, pixels pass through unchanged with the same latency.

Top module: `color_matrix_conv`

## Requirements
- R1: After reset, `out_valid` is 0, all output components are 0, every coefficient word is 0 and conversion is disabled, so pixels pass through unchanged.
- R2: Word 4r+k (k = 0..2) holds the signed row-r coefficient for input column k, with 17 fractional bits (0x00020000 = 1.0). Word 4r+3 holds the signed input offset for column r in bits 31:16 and the signed output constant for row r in bits 15:0, both in component units. Output r = sum over k of coef(r,k)·(in_k + offset_k) + const_r.
- R3: The full-precision sum gets half an LSB (2^16) added before an arithmetic right shift by 17, so an exact .5 result rounds upward.
- R4: A rounded result below 0 becomes 0, and a result above 1023 becomes 1023.
- R5: A pixel sampled at a clock edge with `in_valid` high appears on the outputs after the third rising edge, counting that edge, with `out_valid` high. When `in_valid` is low at that edge, `out_valid` is low in the matching later cycle.
- R6: With conversion disabled, the output components equal the input components, in order c0, c1, c2, with the R5 latency.
- R7: With chroma swap active, coefficient positions 1 and 2 are exchanged within every row. The offsets keep their columns.
- R8: Writes change only the staging bank. Pixels keep using the active bank until a frame-start pulse copies the staging bank into it.
- R9: A write in the same cycle as a frame-start pulse is part of the newly active bank. A pixel sampled together with the pulse uses the new bank, and a pixel sampled one cycle earlier uses the old one.
- R10: Writes to addresses 12 to 15 change no word.
- R11: `conv_en` and `yvu_mode` take effect only when sampled with a frame-start pulse. At any other time they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 4 | Coefficient word index |
| cfg_wdata | input | 32 | Coefficient word data |
| frame_start | input | 1 | Activates staged words and samples the mode levels |
| conv_en | input | 1 | Conversion enable level, sampled at frame start |
| yvu_mode | input | 1 | Chroma column swap level, sampled at frame start |
| in_valid | input | 1 | Input pixel qualifier |
| in_c0 | input | 10 | Input component 0 |
| in_c1 | input | 10 | Input component 1 |
| in_c2 | input | 10 | Input component 2 |
| out_valid | output | 1 | Output pixel qualifier |
| out_c0 | output | 10 | Output component 0 |
| out_c1 | output | 10 | Output component 1 |
| out_c2 | output | 10 | Output component 2 |

## Verification
The case that needs care is a frame-start pulse that lands in the same cycle as a coefficient write and as a pixel. The bench sends one pixel in the cycle before the pulse. It then sends a second pixel together with the pulse and a write that doubles the first coefficient. The first result must still show the old bank, including the chroma swap that was active then. The second result must show the doubled coefficient with the swap turned off. A change that merges the write late, or reads the bank at the wrong pipeline stage, shifts one of the two results.

// File: rtl/color_matrix_conv.sv
`timescale 1ns/1ps
module color_matrix_conv #(
  parameter int PIX_W  = 10,
  parameter int WORD_W = 32,
  parameter int FRAC_W = 17,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              frame_start,
  input  logic              conv_en,
  input  logic              yvu_mode,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  in_c0,
  input  logic [PIX_W-1:0]  in_c1,
  input  logic [PIX_W-1:0]  in_c2,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_c0,
  output logic [PIX_W-1:0]  out_c1,
  output logic [PIX_W-1:0]  out_c2
);
  localparam int ROWS   = 3;
  localparam int NWORDS = ROWS * 4;
  localparam int HALF_W = WORD_W / 2;
  localparam int A_W    = HALF_W + 2;
  localparam int ACC_W  = WORD_W + A_W + 2;
  localparam int SH_W   = ACC_W - FRAC_W;
  localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1) << (FRAC_W - 1);
  localparam logic signed [SH_W-1:0]  MAXV = SH_W'((1 << PIX_W) - 1);

  logic [WORD_W-1:0] shadow [NWORDS];
  logic [WORD_W-1:0] act    [NWORDS];
  logic act_en, act_swap;

  logic [PIX_W-1:0] s1_px [ROWS];
  logic [PIX_W-1:0] s2_px [ROWS];
  logic [PIX_W-1:0] q     [ROWS];
  logic signed [A_W-1:0] col_sum [ROWS];
  logic s1_v, s2_v, s2_en, q_v;

  wire hit = cfg_we && (cfg_addr < ADDR_W'(NWORDS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) begin
        shadow[i] <= '0;
        act[i]    <= '0;
      end
      act_en   <= 1'b0;
      act_swap <= 1'b0;
    end else begin
      if (hit) shadow[cfg_addr] <= cfg_wdata;
      if (frame_start) begin
        for (int i = 0; i < NWORDS; i++)
          act[i] <= (hit && cfg_addr == ADDR_W'(i)) ? cfg_wdata : shadow[i];
        act_en   <= conv_en;
        act_swap <= yvu_mode;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      s2_en <= 1'b0;
      q_v  <= 1'b0;
      for (int j = 0; j < ROWS; j++) begin
        s1_px[j] <= '0;
        s2_px[j] <= '0;
      end
    end else begin
      s1_v     <= in_valid;
      s1_px[0] <= in_c0;
      s1_px[1] <= in_c1;
      s1_px[2] <= in_c2;
      s2_v     <= s1_v;
      s2_en    <= act_en;
      s2_px    <= s1_px;
      q_v      <= s2_v;
    end
  end

  for (genvar j = 0; j < ROWS; j++) begin : g_col
    assign col_sum[j] = $signed({{(A_W-PIX_W){1'b0}}, s1_px[j]})
                      + A_W'($signed(act[4*j+3][WORD_W-1:HALF_W]));
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [WORD_W-1:0] k0, k1, k2;
    logic signed [ACC_W-1:0] acc, acc_q;
    logic signed [SH_W-1:0]  sh;
    logic [PIX_W-1:0] sat, q_r;

    assign k0 = act[4*r];
    assign k1 = act_swap ? act[4*r+2] : act[4*r+1];
    assign k2 = act_swap ? act[4*r+1] : act[4*r+2];

    assign acc = ACC_W'($signed(k0)) * ACC_W'(col_sum[0])
               + ACC_W'($signed(k1)) * ACC_W'(col_sum[1])
               + ACC_W'($signed(k2)) * ACC_W'(col_sum[2])
               + (ACC_W'($signed(act[4*r+3][HALF_W-1:0])) <<< FRAC_W)
               + RND;

    assign sh  = acc_q[ACC_W-1:FRAC_W];
    assign sat = (sh < 0) ? '0 : (sh > MAXV) ? MAXV[PIX_W-1:0] : sh[PIX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q <= '0;
        q_r   <= '0;
      end else begin
        acc_q <= acc;
        q_r   <= s2_en ? sat : s2_px[r];
      end
    end
    assign q[r] = q_r;
  end

  assign out_valid = q_v;
  assign out_c0    = q[0];
  assign out_c1    = q[1];
  assign out_c2    = q[2];
endmodule

// File: rtl/color_matrix_conv_chk.sv
`timescale 1ns/1ps
module color_matrix_conv_chk #(
  parameter int PIX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             conv_en,
  input logic             yvu_mode,
  input logic             in_valid,
  input logic [PIX_W-1:0] in_c0,
  input logic [PIX_W-1:0] in_c1,
  input logic [PIX_W-1:0] in_c2,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_c0,
  input logic [PIX_W-1:0] out_c1,
  input logic [PIX_W-1:0] out_c2,
  input logic             act_en,
  input logic             act_swap
);
  logic [1:0] warm_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_cnt <= '0;
    else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
  end
  wire warm = (warm_cnt == 2'd3);

  assert_valid_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(in_valid, 3)));

  assert_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && !$past(act_en, 2)) |->
      (out_c0 == $past(in_c0, 3) && out_c1 == $past(in_c1, 3) && out_c2 == $past(in_c2, 3)));

  assert_ctrl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(act_en) && $stable(act_swap)));

  assert_ctrl_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (act_en == $past(conv_en) && act_swap == $past(yvu_mode)));
endmodule

bind color_matrix_conv color_matrix_conv_chk #(.PIX_W(PIX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .conv_en(conv_en),
  .yvu_mode(yvu_mode), .in_valid(in_valid), .in_c0(in_c0), .in_c1(in_c1),
  .in_c2(in_c2), .out_valid(out_valid), .out_c0(out_c0), .out_c1(out_c1),
  .out_c2(out_c2), .act_en(act_en), .act_swap(act_swap)
);

// File: tb/color_matrix_conv_tb_top.sv
`timescale 1ns/1ps
module color_matrix_conv_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic frame_start = 1'b0, conv_en = 1'b0, yvu_mode = 1'b0, in_valid = 1'b0;
  logic [9:0] in_c0 = '0, in_c1 = '0, in_c2 = '0;
  logic out_valid;
  logic [9:0] out_c0, out_c1, out_c2;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  color_matrix_conv dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start), .conv_en(conv_en),
    .yvu_mode(yvu_mode), .in_valid(in_valid), .in_c0(in_c0), .in_c1(in_c1),
    .in_c2(in_c2), .out_valid(out_valid), .out_c0(out_c0), .out_c1(out_c1),
    .out_c2(out_c2)
  );

  // Matrix: row0 = x-64; row1 = 0.5*(y-512)+512; row2 = 512-(z-512)
  localparam logic [31:0] MAT [12] = '{
    32'h0002_0000, 32'h0, 32'h0, 32'hFFC0_0000,
    32'h0, 32'h0001_0000, 32'h0, 32'hFE00_0200,
    32'h0, 32'h0, 32'hFFFE_0000, 32'hFE00_0200 };

  // {x, y, z, o0, o1, o2}
  localparam logic [59:0] VEC [6] = '{
    {10'd64,   10'd512,  10'd512, 10'd0,   10'd512, 10'd512},
    {10'd1023, 10'd1023, 10'd0,   10'd959, 10'd768, 10'd1023},
    {10'd0,    10'd0,    10'd1023,10'd0,   10'd256, 10'd1},
    {10'd100,  10'd513,  10'd700, 10'd36,  10'd513, 10'd324},
    {10'd300,  10'd511,  10'd1,   10'd236, 10'd512, 10'd1023},
    {10'd10,   10'd100,  10'd24,  10'd0,   10'd306, 10'd1000} };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic frame(input logic en, input logic swp);
    @(negedge clk); frame_start = 1'b1; conv_en = en; yvu_mode = swp;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic px(input int x, input int y, input int z,
                    input int e0, input int e1, input int e2, input string req);
    @(negedge clk); in_valid = 1'b1; in_c0 = 10'(x); in_c1 = 10'(y); in_c2 = 10'(z);
    @(posedge clk);
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #1 chk({req, " R5 early valid"}, int'(out_valid), 0);
    @(posedge clk); #1 chk({req, " R5 valid"}, int'(out_valid), 1);
    chk({req, " c0"}, int'(out_c0), e0);
    chk({req, " c1"}, int'(out_c1), e1);
    chk({req, " c2"}, int'(out_c2), e2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1 reset valid", int'(out_valid), 0);
    chk("R1 reset c0", int'(out_c0), 0);
    chk("R1 reset c2", int'(out_c2), 0);
    @(negedge clk); rst_n = 1'b1;

    px(7, 8, 9, 7, 8, 9, "R1 R6 disabled after reset");

    conv_en = 1'b1;
    for (int i = 0; i < 12; i++) wr(4'(i), MAT[i]);
    px(64, 512, 512, 64, 512, 512, "R8 R11 staged only");

    frame(1'b1, 1'b0);
    for (int i = 0; i < 6; i++)
      px(VEC[i][59:50], VEC[i][49:40], VEC[i][39:30],
         VEC[i][29:20], VEC[i][19:10], VEC[i][9:0], "R2 R3 R4 table");

    wr(4'd12, 32'h0);
    wr(4'd15, 32'hFFFF_FFFF);
    frame(1'b1, 1'b0);
    px(100, 513, 700, 36, 513, 324, "R10 high address");

    frame(1'b1, 1'b1);
    px(64, 200, 700, 0, 606, 824, "R7 swap");
    yvu_mode = 1'b0;
    px(64, 200, 700, 0, 606, 824, "R11 swap level ignored");

    // R9: pixel before the pulse, then pixel + pulse + write together
    @(negedge clk); in_valid = 1'b1; in_c0 = 10'd100; in_c1 = 10'd512; in_c2 = 10'd512;
    @(posedge clk);
    @(negedge clk); frame_start = 1'b1; conv_en = 1'b1; yvu_mode = 1'b0;
    cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 32'h0004_0000;
    @(posedge clk);
    @(negedge clk); in_valid = 1'b0; frame_start = 1'b0; cfg_we = 1'b0;
    @(posedge clk); #1 chk("R9 old bank valid", int'(out_valid), 1);
    chk("R9 old bank c0", int'(out_c0), 36);
    chk("R9 old bank c2", int'(out_c2), 512);
    @(posedge clk); #1 chk("R9 new bank valid", int'(out_valid), 1);
    chk("R9 new bank c0", int'(out_c0), 72);
    chk("R9 new bank c1", int'(out_c1), 512);

    frame(1'b0, 1'b0);
    px(5, 6, 7, 5, 6, 7, "R6 bypass");
    conv_en = 1'b1;
    px(1020, 3, 0, 1020, 3, 0, "R11 enable level ignored");

    @(negedge clk); in_valid = 1'b1; in_c0 = 10'd900;
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
    #1 chk("R1 mid-run reset valid", int'(out_valid), 0);
    chk("R1 mid-run reset c0", int'(out_c0), 0);
    @(negedge clk); rst_n = 1'b1;
    px(11, 12, 13, 11, 12, 13, "R1 disabled after second reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R5: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule